// File: doc/BRIEF.md
# ISA I/O Chip-Select Decoder

This block drives the I/O chip-select lines of an ISA add-in card. Each select has a 16-bit base address, held as a high byte and a low byte, and a size register. The low byte of the size register is a mask of the form 2^n-1. A bus address hits a select when every address bit that the mask does not cover equals the matching base bit. Only the low `DECODE_W` bits take part in the compare, so the card can use the usual 10-bit ISA I/O decode. A qualification bit for each select picks one of two modes. In the first, a hit on the address alone asserts the select. In the second, the address hit must also coincide with a low read or write strobe.

The logical device must be enabled through its activate bit before any select can assert. While the device is inactive, software can turn on a conflict-check mode. In that mode no select ever asserts. Instead, an I/O read that falls inside any of the programmed ranges makes the block drive a fixed test byte onto the data bus. Software uses the byte it reads back to see whether another card answers in the same range. The block registers all outputs once, on the rising clock edge. Configuration values come straight from registers outside the block.

Top module: `isa_iocs_decoder`

## Requirements
- R1: While `rst_n` is low, `cs_o` is all zero, `rd_drive_o` is 0 and `rd_data_o` is 0x00.
- R2: Select i hits when `(addr | m) == (base | m)` over the decoded bits. Here m is the low 8 bits of size slice i (bits [16i+7:16i] of `cfg_size`). The base is `{cfg_base_hi[8i+7:8i], cfg_base_lo[8i+7:8i]}`. Bits [15:8] of each size slice have no effect. Mask 0x00 covers exactly one address and mask 0x07 covers eight aligned addresses.
- R3: Address bits and base bits at positions 10 and above (`DECODE_W` = 10) have no effect on any hit.
- R4: When `cfg_addr_only[i]` is 1, select i asserts on an address hit whatever the levels of `iord_n` and `iowr_n`.
- R5: When `cfg_addr_only[i]` is 0, select i asserts only if it hits and at least one of `iord_n` and `iowr_n` is low.
- R6: No select asserts unless `cfg_activate[0]` is 1. Bits [7:1] of `cfg_activate` have no effect.
- R7: Range-check mode is on while `cfg_range_chk[1]` is 1 and `cfg_activate[0]` is 0. In this mode no select asserts. `rd_drive_o` is 1 exactly when `iord_n` is low and the address hits at least one select, and a write strobe alone never sets it.
- R8: While `rd_drive_o` is 1, `rd_data_o` is 0x55 if `cfg_range_chk[0]` is 1 and 0xAA if it is 0. While `rd_drive_o` is 0, `rd_data_o` is 0x00.
- R9: While `cfg_activate[0]` is 1, `cfg_range_chk` has no effect: selects decode normally and `rd_drive_o` stays 0.
- R10: Every output shows the inputs sampled at the previous rising edge of `clk`. A change of inputs between edges leaves the outputs unchanged until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| isa_addr | input | 16 | ISA I/O address |
| iord_n | input | 1 | I/O read strobe, active low |
| iowr_n | input | 1 | I/O write strobe, active low |
| cfg_addr_only | input | 3 | Per-select qualification: 1 = address only, 0 = address plus strobe |
| cfg_base_hi | input | 24 | Base address bits [15:8], one byte per select |
| cfg_base_lo | input | 24 | Base address bits [7:0], one byte per select |
| cfg_size | input | 48 | Size registers, 16 bits per select, mask in the low byte |
| cfg_activate | input | 8 | Activate register, bit 0 enables the device |
| cfg_range_chk | input | 8 | Range-check register: bit 1 enable, bit 0 pattern select |
| cs_o | output | 3 | Chip selects, active high |
| rd_drive_o | output | 1 | Read-data drive enable during range check |
| rd_data_o | output | 8 | Byte to drive during range check |

## Verification
The checker's history properties assume two things: every input holds a defined value from the first clock edge, and inputs change only between edges, so the value an output reflects is the one seen at the prior edge. The bench sets every input before it releases reset and drives all stimulus on falling edges. Random size masks are always drawn from the 2^n-1 set, and the reserved upper byte of each size slice is filled with random junk. About half of the addresses are aimed inside a programmed range, with random upper bits, so that hits, strobe qualification and range-check responses all occur often.

// File: rtl/isa_iocs_pkg.sv
package isa_iocs_pkg;

   localparam int unsigned BYTE_W = 8;
   localparam logic [BYTE_W-1:0] PAT_SEL_SET   = 8'h55;
   localparam logic [BYTE_W-1:0] PAT_SEL_CLEAR = 8'hAA;

   // decoded view of the device control registers
   typedef struct packed {
      logic active;    // logical device enabled on the bus
      logic chk_en;    // range-check request
      logic chk_pat;   // range-check pattern select
   } dev_ctrl_t;

   // operating mode after range check is qualified by the activate bit
   typedef enum logic [1:0] {
      MODE_IDLE  = 2'b00,
      MODE_LIVE  = 2'b01,
      MODE_CHECK = 2'b10
   } dev_mode_e;

   function automatic dev_mode_e resolve_mode(dev_ctrl_t c);
      if (c.active)      return MODE_LIVE;
      else if (c.chk_en) return MODE_CHECK;
      else               return MODE_IDLE;
   endfunction

endpackage

// File: rtl/isa_iocs_match.sv
module isa_iocs_match #(
   parameter int unsigned DECODE_W = 10,
   parameter int unsigned MASK_W   = 8
) (
   input  logic [DECODE_W-1:0] addr,
   input  logic [DECODE_W-1:0] base,
   input  logic [MASK_W-1:0]   mask,
   output logic                hit
);
   localparam int unsigned HI_W = DECODE_W - MASK_W;

   logic [DECODE_W-1:0] care;
   logic [DECODE_W-1:0] diff;

   generate
      if (HI_W > 0) begin : g_wide
         assign care = {{HI_W{1'b1}}, ~mask};
      end else begin : g_narrow
         assign care = ~mask[DECODE_W-1:0];
      end
   endgenerate

   assign diff = addr ^ base;
   assign hit  = ((diff & care) == '0);
endmodule

// File: rtl/isa_iocs_qual.sv
module isa_iocs_qual (
   input  logic hit,
   input  logic addr_only,
   input  logic iord_n,
   input  logic iowr_n,
   input  logic live,
   output logic sel
);
   logic strobe;

   assign strobe = ~iord_n | ~iowr_n;
   assign sel    = live & hit & (addr_only | strobe);
endmodule

// File: rtl/isa_iocs_rangechk.sv
module isa_iocs_rangechk
   import isa_iocs_pkg::*;
#(
   parameter int unsigned NUM_CS = 3,
   parameter int unsigned DATA_W = 8
) (
   input  logic [NUM_CS-1:0] hit,
   input  dev_mode_e         mode,
   input  logic              pat_sel,
   input  logic              iord_n,
   output logic              drive,
   output logic [DATA_W-1:0] data
);
   logic any_hit;

   assign any_hit = |hit;
   assign drive   = (mode == MODE_CHECK) & ~iord_n & any_hit;

   always_comb begin
      data = '0;
      if (drive) begin
         data = pat_sel ? DATA_W'(PAT_SEL_SET) : DATA_W'(PAT_SEL_CLEAR);
      end
   end
endmodule

// File: rtl/isa_iocs_decoder.sv
module isa_iocs_decoder
   import isa_iocs_pkg::*;
#(
   parameter int unsigned NUM_CS     = 3,
   parameter int unsigned DECODE_W   = 10,
   parameter int unsigned MASK_W     = 8,
   parameter int unsigned SIZE_REG_W = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [15:0]                isa_addr,
   input  logic                       iord_n,
   input  logic                       iowr_n,
   input  logic [NUM_CS-1:0]          cfg_addr_only,
   input  logic [NUM_CS*8-1:0]        cfg_base_hi,
   input  logic [NUM_CS*8-1:0]        cfg_base_lo,
   input  logic [NUM_CS*SIZE_REG_W-1:0] cfg_size,
   input  logic [7:0]                 cfg_activate,
   input  logic [7:0]                 cfg_range_chk,
   output logic [NUM_CS-1:0]          cs_o,
   output logic                       rd_drive_o,
   output logic [7:0]                 rd_data_o
);
   localparam int unsigned ADDR_W = 2 * BYTE_W;
   localparam int unsigned DATA_W = BYTE_W;

   generate
      if (NUM_CS < 1) begin : g_bad_count
         $error("NUM_CS must be at least 1");
      end
      if (DECODE_W > ADDR_W || DECODE_W < MASK_W) begin : g_bad_decode
         $error("DECODE_W must lie between MASK_W and the address width");
      end
      if (MASK_W > SIZE_REG_W) begin : g_bad_mask
         $error("MASK_W must fit inside the size register");
      end
   endgenerate

   dev_ctrl_t ctrl;
   dev_mode_e mode;
   logic      live;

   assign ctrl.active  = cfg_activate[0];
   assign ctrl.chk_en  = cfg_range_chk[1];
   assign ctrl.chk_pat = cfg_range_chk[0];
   assign mode         = resolve_mode(ctrl);
   assign live         = (mode == MODE_LIVE);

   wire unused_ctrl = ^{cfg_activate[7:1], cfg_range_chk[7:2]};

   logic [DECODE_W-1:0] addr_dec;
   assign addr_dec = isa_addr[DECODE_W-1:0];

   generate
      if (DECODE_W < ADDR_W) begin : g_addr_hi
         wire unused_addr_hi = ^isa_addr[ADDR_W-1:DECODE_W];
      end
   endgenerate

   logic [NUM_CS-1:0] hit;
   logic [NUM_CS-1:0] sel;

   for (genvar gi = 0; gi < NUM_CS; gi++) begin : g_sel
      logic [ADDR_W-1:0]     base_full;
      logic [SIZE_REG_W-1:0] size_full;

      assign base_full = {cfg_base_hi[gi*8 +: 8], cfg_base_lo[gi*8 +: 8]};
      assign size_full = cfg_size[gi*SIZE_REG_W +: SIZE_REG_W];

      if (DECODE_W < ADDR_W) begin : g_base_hi
         wire unused_base_hi = ^base_full[ADDR_W-1:DECODE_W];
      end
      if (MASK_W < SIZE_REG_W) begin : g_size_hi
         wire unused_size_hi = ^size_full[SIZE_REG_W-1:MASK_W];
      end

      isa_iocs_match #(
         .DECODE_W (DECODE_W),
         .MASK_W   (MASK_W)
      ) u_match (
         .addr (addr_dec),
         .base (base_full[DECODE_W-1:0]),
         .mask (size_full[MASK_W-1:0]),
         .hit  (hit[gi])
      );

      isa_iocs_qual u_qual (
         .hit       (hit[gi]),
         .addr_only (cfg_addr_only[gi]),
         .iord_n    (iord_n),
         .iowr_n    (iowr_n),
         .live      (live),
         .sel       (sel[gi])
      );
   end

   logic              chk_drive;
   logic [DATA_W-1:0] chk_data;

   isa_iocs_rangechk #(
      .NUM_CS (NUM_CS),
      .DATA_W (DATA_W)
   ) u_rangechk (
      .hit     (hit),
      .mode    (mode),
      .pat_sel (ctrl.chk_pat),
      .iord_n  (iord_n),
      .drive   (chk_drive),
      .data    (chk_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_o       <= '0;
         rd_drive_o <= 1'b0;
         rd_data_o  <= '0;
      end else begin
         cs_o       <= sel;
         rd_drive_o <= chk_drive;
         rd_data_o  <= chk_data;
      end
   end
endmodule

// File: rtl/isa_iocs_decoder_chk.sv
module isa_iocs_decoder_chk #(
   parameter int unsigned NUM_CS = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              iord_n,
   input logic              iowr_n,
   input logic [NUM_CS-1:0] addr_only,
   input logic              act_bit,
   input logic              chk_en_bit,
   input logic              chk_pat_bit,
   input logic [NUM_CS-1:0] cs,
   input logic              drive,
   input logic [7:0]        data
);
   a_r1_reset_quiet: assert property (@(posedge clk)
      !rst_n |-> (cs == '0 && !drive && data == 8'h00));

   a_r6_cs_needs_active: assert property (@(posedge clk) disable iff (!rst_n)
      (|cs) |-> $past(act_bit));

   a_r7_no_cs_while_checking: assert property (@(posedge clk) disable iff (!rst_n)
      drive |-> (cs == '0));

   a_r7_drive_cause: assert property (@(posedge clk) disable iff (!rst_n)
      drive |-> $past(!iord_n && !act_bit && chk_en_bit));

   a_r8_pattern: assert property (@(posedge clk) disable iff (!rst_n)
      drive |-> (data == ($past(chk_pat_bit) ? 8'h55 : 8'hAA)));

   a_r8_idle_data: assert property (@(posedge clk) disable iff (!rst_n)
      !drive |-> (data == 8'h00));

   a_r9_no_drive_active: assert property (@(posedge clk) disable iff (!rst_n)
      $past(act_bit) |-> !drive);

   for (genvar gi = 0; gi < NUM_CS; gi++) begin : g_strobe
      a_r5_strobe_qual: assert property (@(posedge clk) disable iff (!rst_n)
         (cs[gi] && !$past(addr_only[gi])) |-> $past(!iord_n || !iowr_n));
   end
endmodule

bind isa_iocs_decoder isa_iocs_decoder_chk #(.NUM_CS(NUM_CS)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .iord_n      (iord_n),
   .iowr_n      (iowr_n),
   .addr_only   (cfg_addr_only),
   .act_bit     (cfg_activate[0]),
   .chk_en_bit  (cfg_range_chk[1]),
   .chk_pat_bit (cfg_range_chk[0]),
   .cs          (cs_o),
   .drive       (rd_drive_o),
   .data        (rd_data_o)
);

// File: tb/tb_isa_iocs_decoder.sv
module tb_isa_iocs_decoder;
   localparam int NCS = 3;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic              rst_n;
   logic [15:0]       addr;
   logic              iord_n, iowr_n;
   logic [NCS-1:0]    aonly;
   logic [NCS*8-1:0]  bhi, blo;
   logic [NCS*16-1:0] size;
   logic [7:0]        act, rc;
   logic [NCS-1:0]    cs;
   logic              drv;
   logic [7:0]        dat;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 0;

   isa_iocs_decoder dut (
      .clk (clk), .rst_n (rst_n), .isa_addr (addr),
      .iord_n (iord_n), .iowr_n (iowr_n), .cfg_addr_only (aonly),
      .cfg_base_hi (bhi), .cfg_base_lo (blo), .cfg_size (size),
      .cfg_activate (act), .cfg_range_chk (rc),
      .cs_o (cs), .rd_drive_o (drv), .rd_data_o (dat)
   );

   // expected {cs, drive, data} from the requirements
   function automatic logic [11:0] model();
      logic [2:0] c = '0;
      logic       any_hit = 1'b0;
      logic       d_en;
      logic [9:0] a, b, m;
      for (int i = 0; i < NCS; i++) begin
         m = {2'b00, size[i*16 +: 8]};
         a = addr[9:0];
         b = {bhi[i*8 +: 2], blo[i*8 +: 8]};
         if ((a | m) == (b | m)) begin
            any_hit = 1'b1;
            if (act[0] && (aonly[i] || !iord_n || !iowr_n)) c[i] = 1'b1;
         end
      end
      d_en = !act[0] && rc[1] && !iord_n && any_hit;
      return {c, d_en, d_en ? (rc[0] ? 8'h55 : 8'hAA) : 8'h00};
   endfunction

   task automatic check(string tag, logic [11:0] exp);
      n_run++;
      if ({cs, drv, dat} !== exp) begin
         n_fail++;
         $display("FAIL %s: cs=%b drv=%b data=%h expected cs=%b drv=%b data=%h",
                  tag, cs, drv, dat, exp[11:9], exp[8], exp[7:0]);
      end
   endtask

   task automatic cycle(string tag);
      logic [11:0] e;
      e = model();
      @(posedge clk);
      @(negedge clk);
      check(tag, e);
   endtask

   task automatic set_sel(int i, logic [15:0] base, logic [15:0] sz);
      bhi[i*8 +: 8]  = base[15:8];
      blo[i*8 +: 8]  = base[7:0];
      size[i*16 +: 16] = sz;
   endtask

   initial begin
      #(8 * 150000);
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      if (!done) begin
         done = 1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      end
      $finish;
   end

   initial begin
      logic [11:0] prev;
      int unsigned seed;
      rst_n = 0; addr = 16'h03F8; iord_n = 0; iowr_n = 1;
      aonly = 3'b111; bhi = '0; blo = '0; size = '0; act = 8'h01; rc = 8'h00;
      set_sel(0, 16'h03F8, 16'hA507);
      set_sel(1, 16'h0300, 16'h5A00);
      set_sel(2, 16'h0100, 16'hFF3F);
      repeat (3) @(negedge clk);
      check("R1 reset", 12'h000);
      rst_n = 1;
      aonly = 3'b010;

      // R2 match rule, reserved size bits set in every slice
      addr = 16'h03FF; cycle("R2 top of 8-byte range");
      addr = 16'h03F8; cycle("R2 bottom of 8-byte range");
      addr = 16'h03F7; cycle("R2 just below range");
      addr = 16'h0301; cycle("R2 one-byte range neighbour");
      addr = 16'h013F; cycle("R2 64-byte range top");
      // R3 upper address and base bits ignored
      addr = 16'hFFF8; cycle("R3 upper address bits set");
      set_sel(0, 16'hC3F8, 16'h0007);
      addr = 16'h03FC; cycle("R3 upper base bits set");
      // R4 / R5 qualification
      iord_n = 1; iowr_n = 1;
      addr = 16'h03F8; cycle("R5 no strobe, strobe-qualified");
      addr = 16'h0300; cycle("R4 no strobe, address-only");
      iowr_n = 0; addr = 16'h03FA; cycle("R5 write strobe");
      iowr_n = 1; iord_n = 0;
      // R6 activate gating
      act = 8'hFE; addr = 16'h03F8; cycle("R6 inactive, reserved bits set");
      act = 8'hFF; cycle("R6 active with reserved bits");
      // R7 / R8 range check
      act = 8'h00; rc = 8'h03; addr = 16'h0120; cycle("R7 R8 check 0x55");
      rc = 8'h02; cycle("R8 check 0xAA");
      iord_n = 1; iowr_n = 0; cycle("R7 write strobe only");
      iord_n = 0; iowr_n = 1; addr = 16'h0200; cycle("R7 outside all ranges");
      // R9 range check ignored while active
      act = 8'h01; rc = 8'h03; addr = 16'h03F9; cycle("R9 active with check bits");
      // R10 one-edge latency
      rc = 8'h00; addr = 16'h0200; cycle("R10 prior miss");
      prev = {cs, drv, dat};
      addr = 16'h03F9; #1;
      check("R10 no change before edge", prev);
      cycle("R10 after edge");

      // constrained random
      seed = $urandom(32'd2024);
      for (int n = 0; n < 600; n++) begin
         for (int i = 0; i < NCS; i++) begin
            logic [15:0] m;
            m = 16'((1 << ($urandom % 9)) - 1);
            set_sel(i, 16'($urandom), {8'($urandom), m[7:0]});
         end
         aonly  = 3'($urandom);
         act    = 8'($urandom);
         rc     = 8'($urandom);
         iord_n = 1'($urandom);
         iowr_n = 1'($urandom);
         if ($urandom % 2 == 0) begin
            int k;
            k = int'($urandom % NCS);
            addr = {6'($urandom),
                    ({bhi[k*8 +: 2], blo[k*8 +: 8]} ^ (10'($urandom) & {2'b00, size[k*16 +: 8]}))};
         end else begin
            addr = 16'($urandom);
         end
         cycle("R2 R3 R4 R5 R6 R7 R8 R9 random");
      end

      rst_n = 0; #1;
      check("R1 reset mid-run", 12'h000);

      if (!done) begin
         done = 1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      end
      $finish;
   end
endmodule